// File: doc/BRIEF.md
# Three-Channel Target/Overflow Interrupt Timer

This block holds three independent 16-bit up-counters behind a small register bus. Each channel has a control/status word, a live count and a compare value. A channel counts either the system clock or a selectable slower source, and it wraps either at its compare value or at 0xFFFF. It can flag and interrupt on reaching the compare value, on wrapping past 0xFFFF, or on both. The interrupt fires either once per arming or on every qualifying event. Channel 0 can follow a pixel-rate strobe, channel 1 a line-rate strobe, and channel 2 can run at one eighth of the clock or be halted.

Software arms a channel by writing its control word. That write also zeroes the count. Software then polls the control word, which reports and clears the event flags, or it watches the shared pending register. Each channel owns one bit of that register, and software clears the bit by writing a one to it. The register bus is a plain strobe interface with no back-pressure: a write takes effect at the clock edge where the strobe is seen. Read data is registered and is valid from the edge after the read strobe until the next read.

Top module: `tmr_bank`

## Requirements
- R1: In free-run mode (control bit 3 clear) on the system clock, the count rises by one every clock and goes from 0xFFFF to 0x0000.
- R2: With control bit 3 set, the count becomes 0 instead of the compare value, so with compare value T it cycles 0..T-1.
- R3: A control-word read returns the stored bits 9:0, status bits 12:10, and zeros in bits 15:13. Written bits 15:10 are ignored. Bits 11 and 12 clear after the read, and bit 10 stays set until the next control write.
- R4: Status bit 11 sets when the count reaches the compare value, in either wrap mode. Status bit 12 sets when the count wraps past 0xFFFF. Bit 10 sets on either event. Both event bits set when both events occur in one cycle, and none of these bits depends on the interrupt enables.
- R5: Control bit 4 enables an interrupt on a compare event and bit 5 on a wrap event. With bit 6 set, every enabled event interrupts. With bit 6 clear, only the first one after a control write does.
- R6: A control write loads bits 9:0, zeroes the count, clears the status bits, re-arms the single-shot interrupt and restarts the channel 2 divider.
- R7: With control bit 8 set, channel 0 advances only on cycles with pix_stb high and channel 1 only on cycles with hsync_stb high.
- R8: On channel 2, control bit 9 advances the count once per 8 clocks, the first step coming 8 clocks after the control write. Control bit 0 freezes the count, though count writes still load.
- R9: A compare-value write leaves the count running. A count write loads the written value and takes precedence over that cycle's count step.
- R10: An interrupt from channel i sets bit 4+i of irq_pend. Writing ones to address 0xC clears those bits, and a new interrupt in the same cycle wins.
- R11: Address bits 3:2 pick the channel (0..2) and bits 1:0 the register (0 count, 1 control, 2 compare value). Address 0xC is the pending register. bus_rdata holds the value read at the edge where bus_rd was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| pix_stb | input | 1 | Pixel-rate count enable for channel 0 |
| hsync_stb | input | 1 | Line-rate count enable for channel 1 |
| irq_pend | output | 16 | Shared interrupt-pending register |

## Verification
The count is read after a sweep of delays for each source: the plain clock near the 0xFFFF boundary, compare values 1 through 5 in target-wrap mode, and the divide-by-eight source over 0 to 20 clocks. These sweeps tell an off-by-one wrap apart from a correct one, and show whether the divider's phase is tied to the control write. Strobe-driven channels get sparse pulses with idle clocks between them, so that counting ordinary clocks is exposed. Single-shot and repeating interrupts are compared across clears of the pending bit. A control word read twice shows which status bits are sticky and which clear on read.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  parameter int NUM_TMR  = 3;
  parameter int CNT_W    = 16;
  parameter int ADDR_W   = 4;
  parameter int DIV_W    = 3;
  parameter int IRQ_BASE = 4;

  // control word bit positions
  localparam int B_STOP    = 0;
  localparam int B_TO_TGT  = 3;
  localparam int B_IRQ_TGT = 4;
  localparam int B_IRQ_OVF = 5;
  localparam int B_REPEAT  = 6;
  localparam int B_SRC     = 8;
  localparam int B_DIV     = 9;
  localparam int B_EVT     = 10;
  localparam int B_HIT     = 11;
  localparam int B_WRAP    = 12;

  typedef enum logic [1:0] {
    REG_CNT  = 2'd0,
    REG_CTRL = 2'd1,
    REG_TGT  = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/tmr_tick_sel.sv
module tmr_tick_sel
  import tmr_pkg::*;
#(
  parameter int IDX   = 0,
  parameter int DIV_N = DIV_W
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_wr,
  input  logic src_bit,
  input  logic div_bit,
  input  logic stop_bit,
  input  logic pix_stb,
  input  logic hsync_stb,
  output logic tick
);
  localparam bit HAS_PIX  = (IDX == 0);
  localparam bit HAS_HS   = (IDX == 1);
  localparam bit HAS_DIV  = (IDX == 2);
  localparam bit HAS_STOP = (IDX == 2);

  logic [DIV_N-1:0] pre_q;
  logic             pre_wrap;
  logic             ext_stb;
  logic             use_ext;
  logic             use_div;
  logic             halt;

  always_ff @(posedge clk) begin
    if (!rst_n)       pre_q <= '0;
    else if (ctrl_wr) pre_q <= '0;
    else              pre_q <= pre_q + 1'b1;
  end

  assign pre_wrap = &pre_q;
  assign ext_stb  = HAS_PIX ? pix_stb : hsync_stb;
  assign use_ext  = (HAS_PIX || HAS_HS) && src_bit;
  assign use_div  = HAS_DIV && div_bit;
  assign halt     = HAS_STOP && stop_bit;

  always_comb begin
    if (halt)         tick = 1'b0;
    else if (use_ext) tick = ext_stb;
    else if (use_div) tick = pre_wrap;
    else              tick = 1'b1;
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int IDX = 0,
  parameter int W   = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ctrl_wr,
  input  logic         ctrl_rd,
  input  logic         cnt_wr,
  input  logic         tgt_wr,
  input  logic [W-1:0] wdata,
  input  logic         tick,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] ctrl_o,
  output logic [W-1:0] tgt_o,
  output logic         irq_pulse
);
  localparam int CW = B_EVT;

  logic [CW-1:0] ctl_q;
  logic          evt_q, hit_q, wrap_q;
  logic [W-1:0]  cnt_q, tgt_q, nxt;
  logic          fired_q;
  logic          step, tgt_ev, ovf_ev, want_irq;

  assign nxt      = cnt_q + 1'b1;
  assign step     = tick && !ctrl_wr && !cnt_wr;
  assign tgt_ev   = step && (nxt == tgt_q);
  assign ovf_ev   = step && (&cnt_q);
  assign want_irq = (tgt_ev && ctl_q[B_IRQ_TGT]) || (ovf_ev && ctl_q[B_IRQ_OVF]);
  assign irq_pulse = want_irq && (ctl_q[B_REPEAT] || !fired_q);

  // count register
  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (ctrl_wr) cnt_q <= '0;
    else if (cnt_wr)  cnt_q <= wdata;
    else if (step) begin
      if (ctl_q[B_TO_TGT] && (nxt == tgt_q)) cnt_q <= '0;
      else                                   cnt_q <= nxt;
    end
  end

  // compare value
  always_ff @(posedge clk) begin
    if (!rst_n)      tgt_q <= '0;
    else if (tgt_wr) tgt_q <= wdata;
  end

  // control bits and single-shot state
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q   <= '0;
      fired_q <= 1'b0;
    end else if (ctrl_wr) begin
      ctl_q   <= wdata[CW-1:0];
      fired_q <= 1'b0;
    end else if (irq_pulse) begin
      fired_q <= 1'b1;
    end
  end

  // status bits: an event in the read cycle beats the read clear
  always_ff @(posedge clk) begin
    if (!rst_n || ctrl_wr) begin
      evt_q  <= 1'b0;
      hit_q  <= 1'b0;
      wrap_q <= 1'b0;
    end else begin
      if (tgt_ev || ovf_ev) evt_q <= 1'b1;
      if (tgt_ev)       hit_q <= 1'b1;
      else if (ctrl_rd) hit_q <= 1'b0;
      if (ovf_ev)       wrap_q <= 1'b1;
      else if (ctrl_rd) wrap_q <= 1'b0;
    end
  end

  assign cnt_o  = cnt_q;
  assign tgt_o  = tgt_q;
  assign ctrl_o = {{(W-B_WRAP-1){1'b0}}, wrap_q, hit_q, evt_q, ctl_q};

  // R2: target-wrap mode returns to zero on the compare step
  a_r2_wrap_at_target: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_ev && ctl_q[B_TO_TGT]) |=> (cnt_q == '0));

  // R4: a compare event leaves the hit flag set
  a_r4_hit_flag: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_ev |=> (hit_q && evt_q));

  // R5: single-shot mode never interrupts twice in a row without re-arm
  a_r5_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pulse && !ctl_q[B_REPEAT] && !ctrl_wr) |=> !irq_pulse);

  // R6: a control write zeroes the count and status
  a_r6_ctrl_reset: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (cnt_q == '0 && !hit_q && !wrap_q && !fired_q));

  generate
    if (IDX == 2) begin : g_stop_chk
      // R8: a frozen channel keeps its count
      a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q[B_STOP] && !ctrl_wr && !cnt_wr) |=> $stable(cnt_q));
    end
  endgenerate
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_pkg::*;
#(
  parameter int N  = NUM_TMR,
  parameter int W  = CNT_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic          pix_stb,
  input  logic          hsync_stb,
  output logic [W-1:0]  irq_pend
);
  localparam int SEL_W = AW - 2;
  localparam logic [SEL_W-1:0] PEND_SEL = SEL_W'(3);

  logic [SEL_W-1:0] sel;
  reg_sel_e         rsel;
  logic             pend_hit;
  logic [W-1:0]     cnt_v  [N];
  logic [W-1:0]     ctrl_v [N];
  logic [W-1:0]     tgt_v  [N];
  logic [N-1:0]     irq_v;
  logic [W-1:0]     set_mask;
  logic [W-1:0]     rd_mux;

  assign sel      = bus_addr[AW-1:2];
  assign rsel     = reg_sel_e'(bus_addr[1:0]);
  assign pend_hit = (sel == PEND_SEL) && (rsel == REG_CNT);

  generate
    for (genvar i = 0; i < N; i++) begin : g_ch
      logic hit_i, ctrl_wr_i, ctrl_rd_i, cnt_wr_i, tgt_wr_i, tick_i;
      assign hit_i     = (sel == SEL_W'(i));
      assign ctrl_wr_i = bus_wr && hit_i && (rsel == REG_CTRL);
      assign ctrl_rd_i = bus_rd && hit_i && (rsel == REG_CTRL);
      assign cnt_wr_i  = bus_wr && hit_i && (rsel == REG_CNT);
      assign tgt_wr_i  = bus_wr && hit_i && (rsel == REG_TGT);

      tmr_tick_sel #(.IDX(i)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_wr  (ctrl_wr_i),
        .src_bit  (ctrl_v[i][B_SRC]),
        .div_bit  (ctrl_v[i][B_DIV]),
        .stop_bit (ctrl_v[i][B_STOP]),
        .pix_stb  (pix_stb),
        .hsync_stb(hsync_stb),
        .tick     (tick_i)
      );

      tmr_channel #(.IDX(i), .W(W)) u_ch (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_wr  (ctrl_wr_i),
        .ctrl_rd  (ctrl_rd_i),
        .cnt_wr   (cnt_wr_i),
        .tgt_wr   (tgt_wr_i),
        .wdata    (bus_wdata),
        .tick     (tick_i),
        .cnt_o    (cnt_v[i]),
        .ctrl_o   (ctrl_v[i]),
        .tgt_o    (tgt_v[i]),
        .irq_pulse(irq_v[i])
      );

      // R10: a pulse shows in its pending bit on the next cycle
      a_r10_pend_set: assert property (@(posedge clk) disable iff (!rst_n)
        irq_v[i] |=> irq_pend[IRQ_BASE+i]);
    end
  endgenerate

  always_comb begin
    set_mask = '0;
    for (int i = 0; i < N; i++) set_mask[IRQ_BASE+i] = irq_v[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_pend <= '0;
    else if (bus_wr && pend_hit) irq_pend <= (irq_pend & ~bus_wdata) | set_mask;
    else irq_pend <= irq_pend | set_mask;
  end

  always_comb begin
    rd_mux = '0;
    if (pend_hit) rd_mux = irq_pend;
    for (int i = 0; i < N; i++) begin
      if (sel == SEL_W'(i)) begin
        case (rsel)
          REG_CNT:  rd_mux = cnt_v[i];
          REG_CTRL: rd_mux = ctrl_v[i];
          REG_TGT:  rd_mux = tgt_v[i];
          default:  rd_mux = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: tb/tmr_bank_bench.sv
module tmr_bank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        pix_stb = 1'b0;
  logic        hsync_stb = 1'b0;
  logic [15:0] irq_pend;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  tmr_bank u_tmr_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .pix_stb  (pix_stb),
    .hsync_stb(hsync_stb),
    .irq_pend (irq_pend)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [3:0] ad(input int ch, input int r);
    return 4'((ch << 2) | r);
  endfunction

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state (R11 map, R3 layout)
    chk("R10 pending after reset", irq_pend, 16'h0000);
    rd(ad(0,1), v); chk("R3 ctrl0 after reset", v, 16'h0000);
    rd(ad(1,2), v); chk("R11 tgt1 after reset", v, 16'h0000);

    // R1 free run across 0xFFFF
    for (int k = 0; k < 8; k++) begin
      wr(ad(0,1), 16'h0000);
      wr(ad(0,0), 16'hFFFC);
      idle(k);
      rd(ad(0,0), v);
      chk($sformatf("R1 free run k=%0d", k), v, 16'(32'hFFFC + k));
    end

    // R2 target wrap sweep
    for (int t = 1; t <= 5; t++) begin
      for (int k = 0; k < 12; k++) begin
        wr(ad(0,2), 16'(t));
        wr(ad(0,1), 16'h0008);
        idle(k);
        rd(ad(0,0), v);
        chk($sformatf("R2 T=%0d k=%0d", t, k), v, 16'(k % t));
      end
    end

    // R9 compare write keeps the count
    wr(ad(0,1), 16'h0000);
    idle(4);
    wr(ad(0,2), 16'h0100);
    rd(ad(0,0), v); chk("R9 count kept over compare write", v, 16'd5);
    rd(ad(0,2), v); chk("R11 compare readback", v, 16'h0100);

    // R3 ignored upper bits
    wr(ad(1,2), 16'h0100);
    wr(ad(1,1), 16'hFC58);
    rd(ad(1,1), v); chk("R3 written bits 15:10 ignored", v, 16'h0058);
    wr(ad(1,1), 16'h0000);

    // R4/R3 wrap flag and read clear
    wr(ad(0,1), 16'h0000);
    wr(ad(0,0), 16'hFFFE);
    idle(2);
    rd(ad(0,1), v); chk("R4 wrap sets bits 12 and 10", v, 16'h1400);
    rd(ad(0,1), v); chk("R3 read clears bit 12 keeps bit 10", v, 16'h0400);

    // R4 both events in one cycle, single interrupt
    wr(4'hC, 16'hFFFF);
    wr(ad(0,2), 16'h0000);
    wr(ad(0,1), 16'h0038);
    wr(ad(0,0), 16'hFFFF);
    idle(1);
    rd(ad(0,1), v); chk("R4 compare and wrap together", v, 16'h1C38);
    chk("R10 pending bit4 from channel 0", irq_pend & 16'h0010, 16'h0010);

    // R4 flags without interrupt enables
    wr(4'hC, 16'hFFFF);
    wr(ad(0,2), 16'h0003);
    wr(ad(0,1), 16'h0008);
    idle(6);
    rd(ad(0,1), v); chk("R4 hit flag with irq disabled", v, 16'h0C08);
    chk("R5 no pending when disabled", irq_pend & 16'h0010, 16'h0000);

    // R5 single shot vs repeat
    wr(ad(0,1), 16'h0018);
    idle(10);
    chk("R5 single shot fires", irq_pend & 16'h0010, 16'h0010);
    wr(4'hC, 16'h0010);
    chk("R10 write one clears", irq_pend & 16'h0010, 16'h0000);
    idle(10);
    chk("R5 single shot stays quiet", irq_pend & 16'h0010, 16'h0000);
    wr(ad(0,1), 16'h0058);
    idle(10);
    chk("R5 repeat fires", irq_pend & 16'h0010, 16'h0010);
    wr(4'hC, 16'h0010);
    idle(4);
    chk("R5 repeat fires again", irq_pend & 16'h0010, 16'h0010);
    wr(ad(0,1), 16'h0000);

    // R7 strobe sources
    wr(ad(0,1), 16'h0100);
    idle(3);
    for (int j = 0; j < 4; j++) begin
      pix_stb = 1'b1; @(negedge clk); pix_stb = 1'b0; idle(2);
    end
    rd(ad(0,0), v); chk("R7 channel 0 counts pixel strobes", v, 16'd4);
    wr(ad(1,1), 16'h0100);
    for (int j = 0; j < 6; j++) begin
      hsync_stb = 1'b1; @(negedge clk); hsync_stb = 1'b0; idle(3);
    end
    rd(ad(1,0), v); chk("R7 channel 1 counts line strobes", v, 16'd6);

    // R8 divide by eight sweep
    for (int k = 0; k <= 20; k++) begin
      wr(ad(2,1), 16'h0200);
      idle(k);
      rd(ad(2,0), v);
      chk($sformatf("R8 div8 k=%0d", k), v, 16'(k / 8));
    end

    // R8 freeze, R9 count load
    wr(ad(2,1), 16'h0001);
    idle(9);
    rd(ad(2,0), v); chk("R8 frozen count", v, 16'd0);
    wr(ad(2,0), 16'h0005);
    idle(5);
    rd(ad(2,0), v); chk("R9 count load while frozen", v, 16'd5);

    // R6 control write zeroes count; R10 channel 2 bit
    wr(4'hC, 16'hFFFF);
    wr(ad(2,1), 16'h0020);
    wr(ad(2,0), 16'hFFFF);
    idle(1);
    chk("R10 pending bit6 from channel 2", irq_pend & 16'h0040, 16'h0040);
    wr(ad(2,1), 16'h0000);
    rd(ad(2,0), v); chk("R6 control write zeroes count", v, 16'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule